// File: doc/BRIEF.md
# Multidrop Asynchronous Receiver with Address Wakeup

This block receives words from a shared serial line on which several receivers listen to one talker. The line is sampled on a 16x oversampling tick. Each word opens with a low start bit. Eight data bits follow, least significant first. Then comes one type bit that tells an address word from a data word, and the word closes with a high stop bit.

The receiver holds its own address on a static input. When an address word arrives, the receiver compares it with that address. A match wakes the receiver and raises a one-cycle match flag. From then on it delivers each data word on a byte output with a one-cycle valid strobe. A mismatch puts the receiver to sleep, and it drops every data word until the next address word arrives. The receiver is asleep after reset.

A stop bit that reads low marks a framing error. That word is dropped, and the receiver waits for the line to go idle high before it looks for a new start bit.

Top module: `mdrop_rx`

## Requirements
- R1: After reset `rx_data_o` is 0, and `data_valid_o`, `addr_match_o` and `frame_err_o` are low.
- R2: Each bit is sampled on the ticks numbered 7, 8 and 9 of its 16 ticks. The bit value is the majority of those three samples, so one wrong sample on one tick does not change the received word.
- R3: When a falling edge starts a word but its start bit reads high by majority, the edge is treated as a glitch. No word, flag or error comes of it, and the receiver hunts for a start bit again.
- R4: The word format is one start bit (0), then data bits 0 to 7 in that order, then the type bit (1 = address, 0 = data), then one stop bit (1).
- R5: A stop bit that reads 0 gives a one-cycle `frame_err_o` pulse, and the word is dropped. No new start bit is recognised until the line has read high on a tick.
- R6: An address word equal to `own_addr_i` gives a one-cycle `addr_match_o` pulse and wakes the receiver. Address words never assert `data_valid_o`.
- R7: While awake, each data word appears on `rx_data_o`, with `data_valid_o` high for that cycle.
- R8: An address word that differs from `own_addr_i` gives no `addr_match_o` and puts the receiver to sleep. Data words that arrive while asleep are dropped.
- R9: The receiver is asleep after reset, so it delivers no data word until a matching address word arrives.
- R10: `data_valid_o`, `addr_match_o` and `frame_err_o` are never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe at 16 times the bit rate |
| rx_i | input | 1 | Serial line, asynchronous, idle high |
| own_addr_i | input | 8 | Address of this receiver |
| rx_data_o | output | 8 | Last delivered data byte |
| data_valid_o | output | 1 | A data byte is delivered this cycle |
| addr_match_o | output | 1 | A matching address word was received this cycle |
| frame_err_o | output | 1 | The stop bit of the current word read low |

## Verification
Three internal faults are hard to see: a wrong wake/sleep state, a slip in the tick counter, and a slip in the bit index. Each one shows at the ports within one word time of about 176 ticks. A wrong wake state either delivers a byte from a message the receiver should drop or loses a byte that follows a matching address. A slip in either counter shifts or corrupts the byte value, or turns a good stop bit into a framing error. The directed scenarios therefore check the exact byte values and the exact counts of strobes over each message, including through glitches on the line and through a line held low after a framing error.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_BITS  = 3'd2,
    ST_STOP  = 3'd3,
    ST_WAITH = 3'd4
  } rx_state_e;

  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction
endpackage

// File: rtl/mdrop_sync.sv
module mdrop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= 1'b1;
        else         chain_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= 1'b1;
        else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mdrop_framer.sv
module mdrop_framer
  import mdrop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  output logic              word_valid_o,
  output logic [DATA_W-1:0] word_o,
  output logic              is_addr_o,
  output logic              frame_err_o
);
  localparam int CNT_W  = $clog2(OVS);
  localparam int SHR_W  = DATA_W + 1;
  localparam int IDX_W  = $clog2(SHR_W + 1);
  localparam logic [CNT_W-1:0] SMP_LO = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] SMP_HI = CNT_W'(OVS/2 + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SHR_W - 1);

  rx_state_e        state_q;
  logic [CNT_W-1:0] tcnt_q;
  logic [IDX_W-1:0] bidx_q;
  logic [2:0]       samp_q;
  logic [SHR_W-1:0] shr_q;
  logic             wv_q, ferr_q;

  logic [2:0] samp_n;
  logic       in_win, bit_val;

  assign in_win  = (tcnt_q >= SMP_LO) && (tcnt_q <= SMP_HI);
  assign samp_n  = in_win ? {samp_q[1:0], rx_i} : samp_q;
  assign bit_val = maj3(samp_n);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bidx_q  <= '0;
      samp_q  <= '0;
      shr_q   <= '0;
      wv_q    <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      wv_q   <= 1'b0;
      ferr_q <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: begin
            if (!rx_i) begin
              state_q <= ST_START;
              tcnt_q  <= CNT_W'(1);
            end
          end
          ST_WAITH: begin
            if (rx_i) state_q <= ST_IDLE;
          end
          default: begin
            samp_q <= samp_n;
            tcnt_q <= tcnt_q + 1'b1;
            if (tcnt_q == CNT_END) begin
              unique case (state_q)
                ST_START: begin
                  if (bit_val) state_q <= ST_IDLE;  // glitch, not a start bit
                  else begin
                    state_q <= ST_BITS;
                    bidx_q  <= '0;
                  end
                end
                ST_BITS: begin
                  shr_q <= {bit_val, shr_q[SHR_W-1:1]};
                  if (bidx_q == IDX_LAST) state_q <= ST_STOP;
                  else                    bidx_q  <= bidx_q + 1'b1;
                end
                ST_STOP: begin
                  if (bit_val) begin
                    wv_q    <= 1'b1;
                    state_q <= ST_IDLE;
                  end else begin
                    ferr_q  <= 1'b1;
                    state_q <= ST_WAITH;
                  end
                end
                default: state_q <= ST_IDLE;
              endcase
            end
          end
        endcase
      end
    end
  end

  assign word_valid_o = wv_q;
  assign word_o       = shr_q[DATA_W-1:0];
  assign is_addr_o    = shr_q[DATA_W];
  assign frame_err_o  = ferr_q;

  p_valid_err_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wv_q && ferr_q));
  p_err_waits_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ferr_q |-> state_q == ST_WAITH);
  p_bidx_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bidx_q <= IDX_LAST);
  p_valid_from_stop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wv_q) |-> $past(state_q) == ST_STOP);
endmodule

// File: rtl/mdrop_wake.sv
module mdrop_wake #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              is_addr_i,
  input  logic [DATA_W-1:0] own_addr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_valid_o,
  output logic              addr_match_o
);
  logic              awake_q;
  logic [DATA_W-1:0] data_q;
  logic              dv_q, am_q;
  logic              hit;

  assign hit = (word_i == own_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      awake_q <= 1'b0;  // asleep until addressed
      data_q  <= '0;
      dv_q    <= 1'b0;
      am_q    <= 1'b0;
    end else begin
      dv_q <= 1'b0;
      am_q <= 1'b0;
      if (word_valid_i) begin
        if (is_addr_i) begin
          awake_q <= hit;
          am_q    <= hit;
        end else if (awake_q) begin
          data_q <= word_i;
          dv_q   <= 1'b1;
        end
      end
    end
  end

  assign data_o       = data_q;
  assign data_valid_o = dv_q;
  assign addr_match_o = am_q;

  p_addr_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dv_q && am_q));
  p_data_needs_awake_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dv_q |-> awake_q);
  p_match_wakes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    am_q |-> awake_q);
  p_dv_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dv_q |=> !dv_q);
  p_am_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    am_q |=> !am_q);
endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic [DATA_W-1:0] own_addr_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              data_valid_o,
  output logic              addr_match_o,
  output logic              frame_err_o
);
  logic              rx_s;
  logic              wv;
  logic [DATA_W-1:0] word;
  logic              is_addr;

  mdrop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  mdrop_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .rx_i        (rx_s),
    .word_valid_o(wv),
    .word_o      (word),
    .is_addr_o   (is_addr),
    .frame_err_o (frame_err_o)
  );

  mdrop_wake #(.DATA_W(DATA_W)) u_wake (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .word_valid_i(wv),
    .word_i      (word),
    .is_addr_i   (is_addr),
    .own_addr_i  (own_addr_i),
    .data_o      (rx_data_o),
    .data_valid_o(data_valid_o),
    .addr_match_o(addr_match_o)
  );

  p_ferr_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> !frame_err_o);
endmodule

// File: tb/tb_mdrop_rx.sv
module tb_mdrop_rx;
  localparam logic [7:0] OWN = 8'h3C;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       rx_i = 1'b1;
  logic [7:0] own_addr_i = OWN;
  logic [7:0] rx_data_o;
  logic       data_valid_o, addr_match_o, frame_err_o;

  int errors = 0;
  int checks = 0;
  int n_addr = 0, n_ferr = 0, n_viol = 0;
  logic [7:0] got_q[$];
  logic pdv = 0, pam = 0, pfe = 0;
  int cyc = 0;
  logic [1:0] div_q = '0;

  mdrop_rx dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rx_i(rx_i),
    .own_addr_i(own_addr_i), .rx_data_o(rx_data_o), .data_valid_o(data_valid_o),
    .addr_match_o(addr_match_o), .frame_err_o(frame_err_o)
  );

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    div_q  <= div_q + 1'b1;
    tick_i <= (div_q == 2'd3);
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (data_valid_o) got_q.push_back(rx_data_o);
      if (addr_match_o) n_addr++;
      if (frame_err_o)  n_ferr++;
      if ((data_valid_o && pdv) || (addr_match_o && pam) || (frame_err_o && pfe)) n_viol++;
    end
    pdv = data_valid_o; pam = addr_match_o; pfe = frame_err_o;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic one_tick(input logic v);
    rx_i = v;
    do @(negedge clk_i); while (!tick_i);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) one_tick(1'b1);
  endtask

  // glitch_bit: frame bit index (0=start .. 10=stop) whose tick 8 is inverted; -1 for none
  task automatic send_word(input logic [7:0] d, input logic typ, input logic stop, input int glitch_bit);
    logic [10:0] fr;
    fr = {stop, typ, d, 1'b0};
    for (int b = 0; b < 11; b++)
      for (int t = 0; t < 16; t++)
        one_tick((b == glitch_bit && t == 8) ? ~fr[b] : fr[b]);
  endtask

  task automatic t_reset;
    chk(rx_data_o == 8'h00, "R1", "rx_data after reset", rx_data_o, 0);
    chk(!data_valid_o && !addr_match_o && !frame_err_o, "R1", "flags after reset",
        {data_valid_o, addr_match_o, frame_err_o}, 0);
  endtask

  task automatic t_asleep_after_reset;
    send_word(8'h55, 1'b0, 1'b1, -1);
    idle(6);
    chk(got_q.size() == 0, "R9", "data delivered before any address", got_q.size(), 0);
  endtask

  task automatic t_match;
    int a0 = n_addr;
    send_word(OWN, 1'b1, 1'b1, -1);
    idle(6);
    chk(n_addr == a0 + 1, "R6", "addr_match pulses on own address", n_addr - a0, 1);
    chk(got_q.size() == 0, "R6", "address word on data output", got_q.size(), 0);
    send_word(8'hA5, 1'b0, 1'b1, -1);
    send_word(8'h01, 1'b0, 1'b1, -1);
    idle(6);
    chk(got_q.size() == 2, "R7", "data words delivered", got_q.size(), 2);
    if (got_q.size() == 2) begin
      chk(got_q[0] == 8'hA5, "R4", "first byte lsb-first", got_q[0], 8'hA5);
      chk(got_q[1] == 8'h01, "R7", "second byte", got_q[1], 8'h01);
    end
    got_q.delete();
  endtask

  task automatic t_mismatch;
    int a0 = n_addr;
    send_word(8'h11, 1'b1, 1'b1, -1);
    send_word(8'h77, 1'b0, 1'b1, -1);
    idle(6);
    chk(n_addr == a0, "R8", "no addr_match on foreign address", n_addr - a0, 0);
    chk(got_q.size() == 0, "R8", "data of foreign message dropped", got_q.size(), 0);
    send_word(OWN, 1'b1, 1'b1, -1);
    send_word(8'h42, 1'b0, 1'b1, -1);
    idle(6);
    chk(n_addr == a0 + 1, "R6", "rewake on own address", n_addr - a0, 1);
    chk(got_q.size() == 1 && got_q[0] == 8'h42, "R8", "data after rewake",
        (got_q.size() > 0) ? int'(got_q[0]) : -1, 8'h42);
    got_q.delete();
  endtask

  task automatic t_majority;
    int f0 = n_ferr;
    send_word(8'hA5, 1'b0, 1'b1, 3);
    send_word(8'h5A, 1'b0, 1'b1, 10);
    idle(6);
    chk(got_q.size() == 2, "R2", "words with one bad sample kept", got_q.size(), 2);
    if (got_q.size() == 2) begin
      chk(got_q[0] == 8'hA5, "R2", "data bit glitch voted out", got_q[0], 8'hA5);
      chk(got_q[1] == 8'h5A, "R2", "stop bit glitch voted out", got_q[1], 8'h5A);
    end
    chk(n_ferr == f0, "R2", "no framing error from one sample", n_ferr - f0, 0);
    got_q.delete();
  endtask

  task automatic t_start_glitch;
    int f0 = n_ferr, a0 = n_addr;
    for (int i = 0; i < 3; i++) one_tick(1'b0);
    idle(30);
    chk(got_q.size() == 0 && n_ferr == f0 && n_addr == a0, "R3", "short low pulse produced output",
        got_q.size() + n_ferr - f0 + n_addr - a0, 0);
    send_word(8'hC3, 1'b0, 1'b1, -1);
    idle(6);
    chk(got_q.size() == 1 && got_q[0] == 8'hC3, "R3", "word after rejected glitch",
        (got_q.size() > 0) ? int'(got_q[0]) : -1, 8'hC3);
    got_q.delete();
  endtask

  task automatic t_frame_err;
    int f0 = n_ferr;
    send_word(8'h00, 1'b0, 1'b0, -1);
    for (int i = 0; i < 40; i++) one_tick(1'b0);
    chk(n_ferr == f0 + 1, "R5", "one framing error for held-low line", n_ferr - f0, 1);
    chk(got_q.size() == 0, "R5", "errored word dropped", got_q.size(), 0);
    idle(20);
    chk(got_q.size() == 0 && n_ferr == f0 + 1, "R5", "no word while line held low",
        got_q.size(), 0);
    send_word(8'h9E, 1'b0, 1'b1, -1);
    idle(6);
    chk(got_q.size() == 1 && got_q[0] == 8'h9E, "R5", "recovery after line high",
        (got_q.size() > 0) ? int'(got_q[0]) : -1, 8'h9E);
    got_q.delete();
  endtask

  initial begin
    repeat (5) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    idle(4);
    t_asleep_after_reset();
    t_match();
    t_mismatch();
    t_majority();
    t_start_glitch();
    t_frame_err();
    chk(n_viol == 0, "R10", "flag high on consecutive cycles", n_viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule